// File: doc/BRIEF.md
# SPI Bulk Write Packet Framer

This block sits behind the command stage of a serial-peripheral write path. Once a bulk write command has gone out, it turns the payload into data packets. A bulk write of a given total byte count is split into packets of at most `MAX_PKT` payload bytes. Each packet is sent as a header byte, then its payload bytes, then, when the check field is enabled, two check bytes. Those check bytes are always sent as zero, because computing a real check value belongs to another stage.

The header byte carries a fixed upper nibble of `0xF`. Its two lowest bits tell the receiver where the packet stands in the transfer. Packets follow one another directly, because the far end sends no per-packet response. Payload bytes come in on a valid/ready byte stream and leave on another, so that either side can stall the framer. A start request with a size of four bytes or fewer is refused with a one-cycle reject pulse. A one-cycle done pulse follows the last byte of an accepted transfer.

Top module: `spiw_framer`

## Requirements
- R1: A `start` pulse while idle with `total_size` of 5 or more begins a transfer. `busy` is high from the cycle after that edge until the final byte has been accepted downstream.
- R2: Every header byte equals `0xF0` with a 2-bit order code in bits [1:0]. The code is 3 for the packet that completes the transfer, and this includes a transfer that fits in one packet.
- R3: In a transfer of more than one packet, the first header carries order code 1 and every packet between the first and the last carries order code 2.
- R4: Each packet carries `min(remaining, MAX_PKT)` payload bytes, where remaining is the count not yet sent. Payload bytes leave unaltered and in the order they arrived.
- R5: `crc_en`, sampled with `start`, adds two `0x00` bytes after every packet's payload. When it is low, no such bytes are sent.
- R6: The next header follows the last payload or check byte of the previous packet directly. With `out_ready` held high and no input gaps, a transfer of N output bytes brings `done` exactly N+1 cycles after the `start` edge.
- R7: A `start` while idle with `total_size` of 4 or less raises `reject` for exactly one cycle. `busy` stays low and no byte is sent.
- R8: A `start` while `busy` is ignored: it gives no reject, and it changes neither the current byte sequence nor its length.
- R9: While `out_valid` is high and `out_ready` is low, the output byte holds. Under backpressure no byte is dropped or repeated.
- R10: `done` is a one-cycle pulse in the cycle after the final output byte is accepted, and `busy` is low in that cycle.
- R11: `in_ready` is high only during a payload phase and only while `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new bulk write |
| total_size | input | SIZE_W | Total payload bytes of the request |
| crc_en | input | 1 | Append two check bytes per packet |
| busy | output | 1 | Transfer in progress |
| reject | output | 1 | One-cycle pulse: request size too small |
| done | output | 1 | One-cycle pulse: final byte accepted |
| in_valid | input | 1 | Payload byte available |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Payload byte taken this cycle when valid |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte (header, payload or check) |
| out_ready | input | 1 | Downstream takes the output byte |

## Verification
The bench targets three packet-count boundaries. A transfer of exactly `MAX_PKT` bytes must be a single packet coded 3; a framer that split it would emit an extra empty packet. At `MAX_PKT`+1 bytes the second packet carries one byte, which an off-by-one remaining counter would lose or duplicate. Three packets are needed for a middle header coded 2, and a design that mixed up "first" and "not last" would code that header 1 or 3. Random output stalls and input gaps expose any byte dropped or repeated across a stall, and a gap-free run times `done` to the cycle, so an idle beat inserted between packets would show as lateness. A second `start` during a transfer and sizes of 0, 1 and 4 bytes test the refusal paths, where a loose size compare would send a tiny transfer.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_DATA = 2'd2,
    PH_CRC  = 2'd3
  } phase_t;

  localparam logic [7:0] HDR_BASE  = 8'hF0;
  localparam logic [1:0] ORD_FIRST = 2'd1;
  localparam logic [1:0] ORD_MID   = 2'd2;
  localparam logic [1:0] ORD_LAST  = 2'd3;
  localparam int         MIN_ACCEPT = 5;

  // Position code of a packet: "fits" means the remainder ends in this packet.
  function automatic logic [1:0] order_code(input logic first, input logic fits);
    if (fits)       return ORD_LAST;
    else if (first) return ORD_FIRST;
    else            return ORD_MID;
  endfunction

  function automatic logic [7:0] header_byte(input logic [1:0] ord);
    return HDR_BASE | {6'b0, ord};
  endfunction

endpackage

// File: rtl/spiw_seg.sv
// Tracks remaining transfer bytes and bytes left in the current packet.
module spiw_seg #(
  parameter int SIZE_W  = 24,
  parameter int MAX_PKT = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_size,
  input  logic              hdr_fire,
  input  logic              data_fire,
  output logic              fits,
  output logic              first,
  output logic              pkt_last,
  output logic              xfer_last,
  output logic              rem_zero
);
  localparam int PKT_W = $clog2(MAX_PKT + 1);
  localparam logic [SIZE_W-1:0] MAX_SZ = SIZE_W'(MAX_PKT);

  logic [SIZE_W-1:0] rem;
  logic [PKT_W-1:0]  pkt_left;

  assign fits      = (rem <= MAX_SZ);
  assign pkt_last  = (pkt_left == PKT_W'(1));
  assign xfer_last = (rem == SIZE_W'(1));
  assign rem_zero  = (rem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem      <= '0;
      pkt_left <= '0;
      first    <= 1'b0;
    end else if (load) begin
      rem      <= load_size;
      pkt_left <= '0;
      first    <= 1'b1;
    end else begin
      if (hdr_fire) begin
        first    <= 1'b0;
        pkt_left <= fits ? PKT_W'(rem) : PKT_W'(MAX_PKT);
      end
      if (data_fire) begin
        rem      <= rem - 1'b1;
        pkt_left <= pkt_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiw_seq.sv
// Phase sequencer: header, payload, optional check bytes, repeat.
module spiw_seq (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              size_ok,
  input  logic              crc_req,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic              pkt_last,
  input  logic              xfer_last,
  input  logic              rem_zero,
  output spiw_pkg::phase_t  ph,
  output logic              load,
  output logic              hdr_fire,
  output logic              data_fire,
  output logic              finish
);
  import spiw_pkg::*;

  logic crc_on;
  logic crc_idx;
  logic crc_fire;

  assign load      = (ph == PH_IDLE) && start && size_ok;
  assign hdr_fire  = (ph == PH_HDR) && out_ready;
  assign data_fire = (ph == PH_DATA) && in_valid && out_ready;
  assign crc_fire  = (ph == PH_CRC) && out_ready;
  assign finish    = (data_fire && pkt_last && xfer_last && !crc_on) ||
                     (crc_fire && crc_idx && rem_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      crc_on  <= 1'b0;
      crc_idx <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (load) begin
          ph      <= PH_HDR;
          crc_on  <= crc_req;
          crc_idx <= 1'b0;
        end
        PH_HDR: if (hdr_fire) ph <= PH_DATA;
        PH_DATA: if (data_fire && pkt_last) begin
          if (crc_on)         ph <= PH_CRC;
          else if (xfer_last) ph <= PH_IDLE;
          else                ph <= PH_HDR;
        end
        PH_CRC: if (crc_fire) begin
          if (!crc_idx) crc_idx <= 1'b1;
          else begin
            crc_idx <= 1'b0;
            ph      <= rem_zero ? PH_IDLE : PH_HDR;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiw_omux.sv
// Output byte selection per phase.
module spiw_omux (
  input  spiw_pkg::phase_t ph,
  input  logic [7:0]       hdr_byte,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  output logic [7:0]       out_data
);
  import spiw_pkg::*;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (ph)
      PH_HDR:  begin out_valid = 1'b1;     out_data = hdr_byte; end
      PH_DATA: begin out_valid = in_valid; out_data = in_data;  end
      PH_CRC:  begin out_valid = 1'b1;     out_data = 8'h00;    end
      default: begin out_valid = 1'b0;     out_data = 8'h00;    end
    endcase
  end
endmodule

// File: rtl/spiw_framer.sv
module spiw_framer #(
  parameter int SIZE_W  = 24,
  parameter int MAX_PKT = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] total_size,
  input  logic              crc_en,
  output logic              busy,
  output logic              reject,
  output logic              done,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready
);
  import spiw_pkg::*;

  phase_t     ph;
  logic       size_ok, load, hdr_fire, data_fire, finish;
  logic       fits, first, pkt_last, xfer_last, rem_zero;
  logic [7:0] hdr_byte;
  logic       reject_q, done_q;

  assign size_ok  = (total_size >= SIZE_W'(MIN_ACCEPT));
  assign hdr_byte = header_byte(order_code(first, fits));
  assign busy     = (ph != PH_IDLE);
  assign in_ready = (ph == PH_DATA) && out_ready;

  spiw_seg #(.SIZE_W(SIZE_W), .MAX_PKT(MAX_PKT)) i_seg (
    .clk(clk), .rst_n(rst_n), .load(load), .load_size(total_size),
    .hdr_fire(hdr_fire), .data_fire(data_fire), .fits(fits), .first(first),
    .pkt_last(pkt_last), .xfer_last(xfer_last), .rem_zero(rem_zero)
  );

  spiw_seq i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .size_ok(size_ok),
    .crc_req(crc_en), .in_valid(in_valid), .out_ready(out_ready),
    .pkt_last(pkt_last), .xfer_last(xfer_last), .rem_zero(rem_zero),
    .ph(ph), .load(load), .hdr_fire(hdr_fire), .data_fire(data_fire),
    .finish(finish)
  );

  spiw_omux i_omux (
    .ph(ph), .hdr_byte(hdr_byte), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reject_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      reject_q <= start && !busy && !size_ok;
      done_q   <= finish;
    end
  end

  assign reject = reject_q;
  assign done   = done_q;
endmodule

// File: rtl/spiw_framer_chk.sv
module spiw_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       reject,
  input logic       done,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       hdr_fire
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy); // R7
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R1
  AST_HDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |-> (out_data[7:2] == 6'b111100 && out_data[1:0] != 2'b00)); // R2
  AST_IN_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (out_ready && busy)); // R11
endmodule

bind spiw_framer spiw_framer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .reject(reject),
  .done(done), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .hdr_fire(hdr_fire)
);

// File: tb/test_spiw_framer.sv
module test_spiw_framer;
  localparam int MAXP = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] total_size = '0;
  logic        crc_en = 1'b0;
  logic        busy, reject, done;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b0;

  spiw_framer i_spiw_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .total_size(total_size),
    .crc_en(crc_en), .busy(busy), .reject(reject), .done(done),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  always #5 clk = ~clk;

  int   vectors = 0;
  int   misses  = 0;
  int   cyc     = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit   stall_on = 1'b0;
  bit   done_seen = 1'b0;
  bit   reject_seen = 1'b0;
  int   done_cyc, last_fire_cyc;
  bit   prev_hold = 1'b0;
  logic [7:0] prev_byte;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pat(int i, int n);
    return 8'((i * 7 + n + (i >>> 8)) & 255);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_hold) begin
        check(out_valid && out_data == prev_byte, "R9 hold", {out_valid, out_data}, {1'b1, prev_byte});
      end
      prev_hold = out_valid && !out_ready;
      prev_byte = out_data;
      if (in_ready) check(out_ready == 1'b1, "R11", in_ready, out_ready);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8/R4 unexpected byte", out_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
        last_fire_cyc = cyc;
      end
      if (done) begin done_seen = 1'b1; done_cyc = cyc; end
      if (reject) reject_seen = 1'b1;
    end
  end

  task automatic run_xfer(int n, bit crc, bit gaps, bit stall);
    int rem = n, first = 1, nbytes = 0, scyc;
    while (rem > 0) begin
      int len = (rem < MAXP) ? rem : MAXP;
      logic [1:0] ord = (rem <= MAXP) ? 2'd3 : (first ? 2'd1 : 2'd2);
      exp_q.push_back(8'hF0 | {6'b0, ord});
      tag_q.push_back(ord == 2'd3 ? "R2 header" : "R3 header");
      for (int i = 0; i < len; i++) begin
        exp_q.push_back(pat(n - rem + i, n));
        tag_q.push_back("R4 payload");
      end
      nbytes += len + 1;
      if (crc) begin
        exp_q.push_back(8'h00); tag_q.push_back("R5 check byte");
        exp_q.push_back(8'h00); tag_q.push_back("R5 check byte");
        nbytes += 2;
      end
      rem -= len;
      first = 0;
    end
    stall_on = stall;
    done_seen = 1'b0;
    @(posedge clk); #1;
    start = 1'b1; total_size = 24'(n); crc_en = crc; scyc = cyc;
    @(posedge clk); #1;
    start = 1'b0; crc_en = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R1 busy", busy, 1);
    for (int i = 0; i < n; i++) begin
      bit f;
      if (gaps) begin
        in_valid = 1'b0;
        repeat ($urandom % 3) @(posedge clk);
        #1;
      end
      in_valid = 1'b1; in_data = pat(i, n);
      do begin
        @(negedge clk); f = in_valid && in_ready;
        @(posedge clk); #1;
      end while (!f);
    end
    in_valid = 1'b0;
    while (!done_seen) @(negedge clk);
    check(exp_q.size() == 0, "R4 all bytes out", exp_q.size(), 0);
    check(done_cyc == last_fire_cyc + 1, "R10 done timing", done_cyc, last_fire_cyc + 1);
    if (!gaps && !stall)
      check(done_cyc - scyc == nbytes + 1, "R6 back-to-back", done_cyc - scyc, nbytes + 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10 pulse", {done, busy}, 0);
    stall_on = 1'b0;
  endtask

  task automatic reject_try(int n);
    @(posedge clk); #1;
    start = 1'b1; total_size = 24'(n);
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(reject == 1'b1 && busy == 1'b0 && out_valid == 1'b0, "R7 reject", {reject, busy, out_valid}, 3'b100);
    @(negedge clk);
    check(reject == 1'b0 && busy == 1'b0, "R7 single pulse", {reject, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && out_valid == 0 && done == 0 && reject == 0 && in_ready == 0,
          "R1 reset state", {busy, out_valid, done, reject, in_ready}, 0);
    run_xfer(5, 1'b0, 1'b0, 1'b0);
    run_xfer(5, 1'b1, 1'b0, 1'b0);
    reject_try(4);
    reject_try(0);
    reject_try(1);
    run_xfer(MAXP, 1'b1, 1'b0, 1'b0);
    run_xfer(MAXP + 1, 1'b0, 1'b1, 1'b1);
    run_xfer(2 * MAXP + 5, 1'b1, 1'b0, 1'b0);
    reject_seen = 1'b0;
    fork
      run_xfer(300, 1'b1, 1'b0, 1'b0);
      begin
        repeat (40) @(posedge clk);
        #1 start = 1'b1; total_size = 24'd50;
        @(posedge clk);
        #1 start = 1'b0;
      end
    join
    check(reject_seen == 1'b0, "R8 start while busy", reject_seen, 0);
    reject_seen = 1'b0;
    fork
      run_xfer(200, 1'b1, 1'b0, 1'b0);
      begin
        repeat (60) @(posedge clk);
        #1 start = 1'b1; total_size = 24'd2;
        @(posedge clk);
        #1 start = 1'b0;
      end
    join
    check(reject_seen == 1'b0, "R8 small start while busy", reject_seen, 0);
    run_xfer(1000, 1'b1, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule